// File: doc/BRIEF.md
# Token-Passing Transmit Handshake Sequencer

This block runs the transmit side of a node on a token-passing network. The host writes a packet into the local buffer, one byte at a time. It then gives a start command that carries the packet length and the destination ID. The sequencer waits until the node holds the token. It then sends a one-beat enquiry to the destination to ask whether that node has a free receive buffer.

On a positive reply, the sequencer streams the packet bytes and then a 16-bit CRC. It then waits for the destination to confirm delivery. A negative reply, or silence, makes the node hand the token on with the packet still pending, and the next token retries the enquiry. Once the final reply arrives or its window expires, the sequencer does three things: it records delivered or failed, it marks the transmitter free again, and it passes the token. A host-written mask selects which status bits drive the interrupt line.

Outgoing frames leave through a byte stream with a valid/ready handshake. Replies come in as a single-cycle strobe with a positive/negative flag.

Top module: `tokxmit_seq`

## Requirements
- R1: After a synchronous reset, `status` is 3'b001, and `irq`, `tx_valid` and `token_pass` are all 0.
- R2: With nothing pending, a `token_in` pulse gives a one-cycle `token_pass` on the next cycle. `host_start` in that state latches length and destination and clears `status[0]` (transmitter free) on the next cycle. A further `host_start` while a packet is pending is ignored.
- R3: When a pending packet sees `token_in`, the next cycle shows one enquiry beat. It has `tx_kind`=2'd1, `tx_byte`=destination ID and `tx_last`=1.
- R4: A beat with `tx_valid`=1 keeps `tx_byte`, `tx_kind` and `tx_last` unchanged until a cycle with `tx_ready`=1 accepts it.
- R5: After a positive reply (`rx_valid`=1, `rx_ack`=1), a data frame follows with `tx_kind`=2'd2. It carries buffer bytes from address 0 up to length-1 in order, then the CRC high byte, then the CRC low byte. `tx_last` is set only on the CRC low byte. A length of 0 sends only the two CRC bytes.
- R6: The CRC covers the packet bytes only. It uses polynomial 0x8005 with initial value 0, data processed most significant bit first, no reflection and no final inversion.
- R7: A negative reply to the enquiry gives `token_pass` on the next cycle and sends no data. The packet stays pending, and the next token repeats the enquiry.
- R8: If no reply arrives in the RESP_TO cycles after the enquiry is accepted, `token_pass` is raised exactly RESP_TO cycles after that acceptance, and the packet stays pending.
- R9: After the CRC low byte is accepted, the result is set within RESP_TO cycles. A positive reply sets `status`=3'b011 (free, delivered). A negative reply or no reply sets 3'b101 (free, failed). `token_pass` pulses in the same cycle as the result.
- R10: The delivered and failed bits are cleared by `host_start`, are 0 while the transmitter is busy, and are never 1 together.
- R11: `irq` is 1 exactly when some status bit and its mask bit are both 1. A mask write takes effect in the next cycle. Mask bit n enables status bit n.
- R12: `rx_valid` outside the two reply windows has no effect on status, token or frame output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Write one packet byte into the buffer |
| host_wr_addr | input | AW | Buffer write address |
| host_wr_data | input | 8 | Buffer write byte |
| host_start | input | 1 | Transmit-enable command |
| host_len | input | AW+1 | Packet length in bytes, 0 to 2**AW |
| host_dest | input | 8 | Destination node ID |
| mask_wr_en | input | 1 | Write the interrupt mask |
| mask_wr_data | input | 3 | New interrupt mask |
| token_in | input | 1 | Token has arrived at this node (pulse) |
| token_pass | output | 1 | Hand the token onward (pulse) |
| tx_valid | output | 1 | Outgoing beat valid |
| tx_ready | input | 1 | Outgoing beat accepted |
| tx_kind | output | 2 | Beat kind: 1 enquiry, 2 data frame |
| tx_byte | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final beat of the frame |
| rx_valid | input | 1 | Reply received (pulse) |
| rx_ack | input | 1 | Reply is positive (1) or negative (0) |
| status | output | 3 | bit0 transmitter free, bit1 delivered, bit2 failed |
| irq | output | 1 | Masked status interrupt |

## Verification
Each result has a fixed delay. The enquiry beat appears one cycle after the token is sampled. A token hand-off follows a reply one cycle after the reply is sampled. Status and `irq` change on that same edge. A silent enquiry ends in a hand-off exactly RESP_TO cycles after the enquiry beat is taken. The bench drives inputs and samples outputs on the falling edge. It checks each result on the falling edge that follows the rising edge where the result is due, and it counts cycles for the timeout case so that the exact delay is what gets compared. Backpressured runs hold `tx_ready` low on alternate cycles to show that beats stay unchanged until they are accepted.

// File: rtl/tokxmit_pkg.sv
package tokxmit_pkg;

  localparam logic [1:0] KIND_NONE = 2'd0;
  localparam logic [1:0] KIND_ENQ  = 2'd1;
  localparam logic [1:0] KIND_DATA = 2'd2;

  localparam int NSTAT   = 3;
  localparam int ST_FREE = 0;
  localparam int ST_DONE = 1;
  localparam int ST_FAIL = 2;

  localparam logic [15:0] CRC_POLY = 16'h8005;

  // one byte through the CRC shift register, msb first
  function automatic logic [15:0] crc16_step(input logic [15:0] cin, input logic [7:0] d);
    logic [15:0] c;
    c = cin;
    for (int b = 7; b >= 0; b--) begin
      if (c[15] ^ d[b]) c = {c[14:0], 1'b0} ^ CRC_POLY;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/tokxmit_buf.sv
module tokxmit_buf #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tokxmit_crc.sv
module tokxmit_crc (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_q,
  output logic [15:0] crc_nx
);
  import tokxmit_pkg::*;

  assign crc_nx = crc16_step(crc_q, din);

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '0;
    else if (en)    crc_q <= crc_nx;
  end
endmodule

// File: rtl/tokxmit_stat.sv
module tokxmit_stat
  import tokxmit_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ev,
  input  logic             done_ok,
  input  logic             done_fail,
  input  logic             mask_we,
  input  logic [NSTAT-1:0] mask_din,
  output logic [NSTAT-1:0] stat,
  output logic             irq
);
  logic [NSTAT-1:0] mask, stat_n, mask_n;

  always_comb begin
    stat_n = stat;
    mask_n = mask_we ? mask_din : mask;
    if (start_ev) stat_n = '0;
    if (done_ok) begin
      stat_n[ST_FREE] = 1'b1;
      stat_n[ST_DONE] = 1'b1;
    end
    if (done_fail) begin
      stat_n[ST_FREE] = 1'b1;
      stat_n[ST_FAIL] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= NSTAT'(1);
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_n;
      mask <= mask_n;
      irq  <= |(stat_n & mask_n);
    end
  end
endmodule

// File: rtl/tokxmit_seq.sv
module tokxmit_seq
  import tokxmit_pkg::*;
#(
  parameter int AW      = 6,
  parameter int RESP_TO = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr_en,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [7:0]    host_wr_data,
  input  logic          host_start,
  input  logic [AW:0]   host_len,
  input  logic [7:0]    host_dest,
  input  logic          mask_wr_en,
  input  logic [2:0]    mask_wr_data,
  input  logic          token_in,
  output logic          token_pass,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [1:0]    tx_kind,
  output logic [7:0]    tx_byte,
  output logic          tx_last,
  input  logic          rx_valid,
  input  logic          rx_ack,
  output logic [2:0]    status,
  output logic          irq
);
  localparam int LW = AW + 1;
  localparam int TW = $clog2(RESP_TO + 1);
  localparam logic [TW-1:0] CNT_END = TW'(RESP_TO - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WTOK, S_ENQ, S_WREP, S_RD, S_LD, S_DAT, S_CRCH, S_CRCL, S_WACK
  } state_e;

  state_e        st;
  logic [LW-1:0] len_q, idx;
  logic [7:0]    dest_q;
  logic [TW-1:0] cnt;
  logic [7:0]    rd_data;
  logic [15:0]   crc_q, crc_nx;
  logic          start_ev, done_ok, done_fail, crc_clr, crc_en;
  logic          last_byte, cnt_end;

  tokxmit_buf #(.AW(AW), .DW(8)) u_buf (
    .clk   (clk),
    .we    (host_wr_en),
    .waddr (host_wr_addr),
    .wdata (host_wr_data),
    .raddr (idx[AW-1:0]),
    .rdata (rd_data)
  );

  tokxmit_crc u_crc (
    .clk    (clk),
    .rst    (rst),
    .clr    (crc_clr),
    .en     (crc_en),
    .din    (tx_byte),
    .crc_q  (crc_q),
    .crc_nx (crc_nx)
  );

  tokxmit_stat u_stat (
    .clk       (clk),
    .rst       (rst),
    .start_ev  (start_ev),
    .done_ok   (done_ok),
    .done_fail (done_fail),
    .mask_we   (mask_wr_en),
    .mask_din  (mask_wr_data),
    .stat      (status),
    .irq       (irq)
  );

  always_comb begin
    cnt_end   = (cnt == CNT_END);
    last_byte = ((idx + LW'(1)) == len_q);
    start_ev  = (st == S_IDLE) && host_start;
    crc_clr   = (st == S_WTOK) && token_in;
    crc_en    = (st == S_DAT) && tx_ready;
    done_ok   = (st == S_WACK) && rx_valid && rx_ack;
    done_fail = (st == S_WACK) && ((rx_valid && !rx_ack) || (!rx_valid && cnt_end));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      len_q      <= '0;
      dest_q     <= '0;
      idx        <= '0;
      cnt        <= '0;
      tx_valid   <= 1'b0;
      tx_kind    <= KIND_NONE;
      tx_byte    <= '0;
      tx_last    <= 1'b0;
      token_pass <= 1'b0;
    end else begin
      token_pass <= 1'b0;
      case (st)
        S_IDLE: begin
          if (token_in) token_pass <= 1'b1;
          if (host_start) begin
            len_q  <= host_len;
            dest_q <= host_dest;
            st     <= S_WTOK;
          end
        end
        S_WTOK: begin
          if (token_in) begin
            tx_valid <= 1'b1;
            tx_kind  <= KIND_ENQ;
            tx_byte  <= dest_q;
            tx_last  <= 1'b1;
            st       <= S_ENQ;
          end
        end
        S_ENQ: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            tx_kind  <= KIND_NONE;
            tx_last  <= 1'b0;
            cnt      <= '0;
            st       <= S_WREP;
          end
        end
        S_WREP: begin
          if (rx_valid && rx_ack) begin
            idx <= '0;
            if (len_q == '0) begin
              tx_valid <= 1'b1;
              tx_kind  <= KIND_DATA;
              tx_byte  <= crc_q[15:8];
              st       <= S_CRCH;
            end else begin
              st <= S_RD;
            end
          end else if (rx_valid || cnt_end) begin
            token_pass <= 1'b1;
            st         <= S_WTOK;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        S_RD: st <= S_LD;
        S_LD: begin
          tx_valid <= 1'b1;
          tx_kind  <= KIND_DATA;
          tx_byte  <= rd_data;
          tx_last  <= 1'b0;
          st       <= S_DAT;
        end
        S_DAT: begin
          if (tx_ready) begin
            idx <= idx + LW'(1);
            if (last_byte) begin
              tx_byte <= crc_nx[15:8];
              st      <= S_CRCH;
            end else begin
              tx_valid <= 1'b0;
              tx_kind  <= KIND_NONE;
              st       <= S_RD;
            end
          end
        end
        S_CRCH: begin
          if (tx_ready) begin
            tx_byte <= crc_q[7:0];
            tx_last <= 1'b1;
            st      <= S_CRCL;
          end
        end
        S_CRCL: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            tx_kind  <= KIND_NONE;
            tx_last  <= 1'b0;
            cnt      <= '0;
            st       <= S_WACK;
          end
        end
        S_WACK: begin
          if (rx_valid || cnt_end) begin
            token_pass <= 1'b1;
            st         <= S_IDLE;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tokxmit_chk.sv
module tokxmit_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_start,
  input logic       token_pass,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [1:0] tx_kind,
  input logic [7:0] tx_byte,
  input logic       tx_last,
  input logic [2:0] status
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_kind) && $stable(tx_last));

  assert_enq_single_R3: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_kind == 2'd1 |-> tx_last);

  assert_kind_known_R5: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_kind != 2'd0);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    host_start && status[0] |=> !status[0]);

  assert_result_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(status[1] && status[2]));

  assert_busy_clean_R10: assert property (@(posedge clk) disable iff (rst)
    !status[0] |-> !status[1] && !status[2]);

  assert_pass_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    token_pass |-> !tx_valid);
endmodule

bind tokxmit_seq tokxmit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_start (host_start),
  .token_pass (token_pass),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_kind    (tx_kind),
  .tx_byte    (tx_byte),
  .tx_last    (tx_last),
  .status     (status)
);

// File: tb/tokxmit_seq_test.sv
`timescale 1ns/1ps
module tokxmit_seq_test;
  localparam int AW = 6;
  localparam int RT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr_en = 0, host_start = 0, mask_wr_en = 0, token_in = 0;
  logic tx_ready = 0, rx_valid = 0, rx_ack = 0;
  logic [AW-1:0] host_wr_addr = '0;
  logic [7:0] host_wr_data = '0, host_dest = '0;
  logic [AW:0] host_len = '0;
  logic [2:0] mask_wr_data = '0;
  logic token_pass, tx_valid, tx_last, irq;
  logic [1:0] tx_kind;
  logic [7:0] tx_byte;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tokxmit_seq #(.AW(AW), .RESP_TO(RT)) uut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .host_start(host_start), .host_len(host_len),
    .host_dest(host_dest), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .token_in(token_in), .token_pass(token_pass), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_kind(tx_kind), .tx_byte(tx_byte), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ack(rx_ack), .status(status), .irq(irq)
  );

  // reply codes: 0 positive, 1 negative, 2 silent
  typedef struct packed {
    logic [6:0] len;
    logic [7:0] seed;
    logic [1:0] rep;
    logic [1:0] fin;
    logic [2:0] mask;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{len: 7'd4,  seed: 8'h11, rep: 2'd0, fin: 2'd0, mask: 3'b010},
    '{len: 7'd1,  seed: 8'hA5, rep: 2'd0, fin: 2'd2, mask: 3'b100},
    '{len: 7'd64, seed: 8'h3C, rep: 2'd1, fin: 2'd0, mask: 3'b000},
    '{len: 7'd0,  seed: 8'h00, rep: 2'd0, fin: 2'd0, mask: 3'b001},
    '{len: 7'd7,  seed: 8'h9E, rep: 2'd2, fin: 2'd1, mask: 3'b110},
    '{len: 7'd3,  seed: 8'h42, rep: 2'd0, fin: 2'd0, mask: 3'b100}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  function automatic logic [15:0] model_crc(input int len, input logic [7:0] seed);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d = pbyte(seed, i);
      for (int b = 0; b < 8; b++) begin
        logic top = c[15] ^ d[7-b];
        c = {c[14:0], 1'b0};
        if (top) c = c ^ 16'h8005;
      end
    end
    return c;
  endfunction

  task automatic load_pkt(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      host_wr_en = 1; host_wr_addr = AW'(i); host_wr_data = pbyte(seed, i);
      tick();
    end
    host_wr_en = 0;
  endtask

  task automatic start(input int len, input logic [7:0] dest);
    host_start = 1; host_len = (AW+1)'(len); host_dest = dest;
    tick();
    host_start = 0;
  endtask

  task automatic write_mask(input logic [2:0] m);
    mask_wr_en = 1; mask_wr_data = m;
    tick();
    mask_wr_en = 0;
  endtask

  task automatic give_token();
    token_in = 1;
    tick();
    token_in = 0;
  endtask

  task automatic reply(input logic ack);
    rx_valid = 1; rx_ack = ack;
    tick();
    rx_valid = 0; rx_ack = 0;
  endtask

  // called right after give_token: the beat must already be there
  task automatic take_enq(input logic [7:0] dest);
    chk("R3 enquiry valid one cycle after token", 32'(tx_valid), 1);
    chk("R3 enquiry kind", 32'(tx_kind), 1);
    chk("R3 enquiry carries destination", 32'(tx_byte), 32'(dest));
    chk("R3 enquiry single beat", 32'(tx_last), 1);
    tx_ready = 1;
    tick();
    tx_ready = 0;
  endtask

  task automatic wait_pass(output int n);
    n = -1;
    for (int i = 0; i < 4 * RT; i++) begin
      if (token_pass) begin n = i; break; end
      tick();
    end
  endtask

  task automatic take_data(input int len, input logic [7:0] seed, input bit bp);
    logic [15:0] crc = model_crc(len, seed);
    int got = 0;
    int total = len + 2;
    for (int n = 0; n < 2000; n++) begin
      logic rdy = bp ? n[0] : 1'b1;
      tx_ready = rdy;
      if (tx_valid && rdy) begin
        logic [7:0] exp = (got < len) ? pbyte(seed, got) :
                          (got == len) ? crc[15:8] : crc[7:0];
        if (got < len) chk("R5 data byte order", 32'(tx_byte), 32'(exp));
        else           chk("R6 crc byte", 32'(tx_byte), 32'(exp));
        chk("R5 data kind", 32'(tx_kind), 2);
        chk("R5 last flag", 32'(tx_last), 32'(got == total - 1));
        got++;
        if (got == total) begin
          tick();
          tx_ready = 0;
          break;
        end
      end
      tick();
    end
    tx_ready = 0;
    chk("R5 beat count", 32'(got), 32'(total));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 status after reset", 32'(status), 32'h1);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 tx_valid after reset", 32'(tx_valid), 0);
    chk("R1 token_pass after reset", 32'(token_pass), 0);

    // R2 token with nothing pending is handed on next cycle
    give_token();
    chk("R2 idle token passed", 32'(token_pass), 1);
    chk("R2 idle token no beat", 32'(tx_valid), 0);
    tick();
    chk("R2 pass is one cycle", 32'(token_pass), 0);

    // R12 reply while idle is ignored
    reply(1'b1);
    chk("R12 idle reply status", 32'(status), 32'h1);
    chk("R12 idle reply token", 32'(token_pass), 0);
    chk("R12 idle reply beat", 32'(tx_valid), 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      logic [7:0] dest = 8'h40 + 8'(v);
      logic [2:0] exp_st = (t.fin == 2'd0) ? 3'b011 : 3'b101;
      write_mask(t.mask);
      load_pkt(int'(t.len), t.seed);
      start(int'(t.len), dest);
      chk("R10 busy status cleared", 32'(status), 0);
      give_token();
      take_enq(dest);
      if (t.rep != 2'd0) begin
        if (t.rep == 2'd1) begin
          reply(1'b0);
          chk("R7 negative reply passes token", 32'(token_pass), 1);
        end else begin
          wait_pass(n);
          chk("R8 silent enquiry timeout cycles", 32'(n), 32'(RT));
        end
        chk("R7 no data after refused enquiry", 32'(tx_valid), 0);
        chk("R7 packet still pending", 32'(status), 0);
        tick();
        give_token();
        take_enq(dest);
      end
      reply(1'b1);
      take_data(int'(t.len), t.seed, v[0]);
      if (t.fin == 2'd0) reply(1'b1);
      else if (t.fin == 2'd1) reply(1'b0);
      wait_pass(n);
      if (t.fin == 2'd2) chk("R9 final timeout cycles", 32'(n), 32'(RT));
      else               chk("R9 pass right after reply", 32'(n), 0);
      chk("R9 result status", 32'(status), 32'(exp_st));
      chk("R11 irq from mask", 32'(irq), 32'(|(exp_st & t.mask)));
      tick();
    end

    // R2 second start while pending is ignored; R12 reply while waiting for token ignored
    load_pkt(2, 8'h5A);
    start(2, 8'h21);
    chk("R2 start clears free bit", 32'(status), 0);
    start(5, 8'h99);
    reply(1'b1);
    chk("R12 reply before token no beat", 32'(tx_valid), 0);
    give_token();
    take_enq(8'h21);
    reply(1'b1);
    take_data(2, 8'h5A, 1'b0);
    reply(1'b1);
    wait_pass(n);
    chk("R2 first start kept", 32'(status), 32'h3);

    // R11 mask changes take effect next cycle
    write_mask(3'b000);
    chk("R11 mask none", 32'(irq), 0);
    write_mask(3'b010);
    chk("R11 mask delivered", 32'(irq), 1);
    write_mask(3'b100);
    chk("R11 mask failed bit clear", 32'(irq), 0);
    write_mask(3'b001);
    chk("R11 mask free bit", 32'(irq), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule